// File: doc/BRIEF.md
# Bus-master clock divider and module-stop control

This unit sets the clock rate of a bus master and the stop lines of the peripherals around it. A control register selects one of two rates for the bus master. In high-speed mode the master advances on every cycle of the system clock. In medium-speed mode it advances once every 2, 4, 8, 16 or 32 cycles. Rather than deriving a new clock, the unit emits a one-cycle clock-enable pulse from a free-running 5-bit prescaler. A new rate choice is adopted only when the prescaler rolls over, so no enable period is ever cut short.

The same register holds a disable bit for a clock output pin. The pin carries a half-rate square wave of the system clock, and how it behaves depends on the power mode reported on `pwr_mode`. A second register, 16 bits wide, drives one stop line per peripheral. It keeps its contents through software standby. Hardware standby forces it back to its reset pattern. Software reaches both registers through a simple select/write port with a combinational read path.

Top module: `clkdiv_ctl`

## Requirements
- R1: `rst_n` clears asynchronously, and internal state leaves reset on the second rising clock edge after `rst_n` rises. In reset, the control register reads 0x0000, the stop register reads 0x3FFF, `mstop_o` is 0x3FFF, `clkout_o` is 1 and `clkout_oe` is 1.
- R2: With `reg_sel`=0 the control register is written from `reg_wdata[7:0]` and read on `reg_rdata`. Bit 7 (pin disable), bit 6 (spare) and bits 2:0 (rate code) read back what was written. Bits 15:8 and 5:3 always read 0, whatever was written to them.
- R3: With `reg_sel`=1 all 16 bits of the stop register are written and read back, and `mstop_o` equals the register bit for bit (1 = halt that peripheral).
- R4: In any cycle where `pwr_mode` is hardware standby (11), the stop register is loaded with 0x3FFF at that edge and ignores writes. Software standby (10) leaves its contents untouched.
- R5: A 5-bit prescaler starts at 0 when reset leaves and increments every cycle. Rate codes 000, 110 and 111 give `bm_ce`=1 on every cycle. A code k from 1 to 5 gives `bm_ce`=1 only when the low k prescaler bits are all 1.
- R6: The rate code in use is replaced by the register's code only at the edge where the prescaler goes from 31 to 0.
- R7: In software standby (10) and hardware standby (11), `bm_ce` is 0.
- R8: In normal run (00) and sleep (01) with bit 7 clear, `clkout_o` inverts at every edge. With bit 7 set, `clkout_o` is 1 from the next edge on.
- R9: In software standby, `clkout_o` is 1 from the next edge on, whatever bit 7 holds.
- R10: `clkout_oe` is 0 after every edge at which `pwr_mode` is hardware standby, and 1 after every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_mode | input | 2 | 00 run, 01 sleep, 10 software standby, 11 hardware standby |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 control register, 1 stop register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| bm_ce | output | 1 | Bus-master clock enable |
| clkout_o | output | 1 | Clock output pin value |
| clkout_oe | output | 1 | Clock output pin enable (0 = high impedance) |
| mstop_o | output | 16 | Per-peripheral stop lines |

## Verification
The properties assume that `pwr_mode` is a registered, glitch-free input and that it changes only at clock edges. A mode held across an edge therefore governs the pin and the stop register after that edge. They also assume the prescaler is never reloaded except by reset. That assumption makes the rate-hold check a question of whether the count sits at 31. The stimulus drives every input just after the falling edge, and it changes the mode only now and then. This gives hardware and software standby stretches that last several cycles. Writes land at random prescaler phases, including mid-frame rate changes and writes during both standby modes.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    PM_RUN    = 2'b00,
    PM_SLEEP  = 2'b01,
    PM_SWSTBY = 2'b10,
    PM_HWSTBY = 2'b11
  } pmode_e;

  localparam int CTL_DIS_BIT   = 7;
  localparam int CTL_SPARE_BIT = 6;

  function automatic logic pm_is_active(pmode_e m);
    return (m == PM_RUN) || (m == PM_SLEEP);
  endfunction
endpackage

// File: rtl/clkdiv_rstsync.sv
module clkdiv_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
  parameter int                DATA_W    = 16,
  parameter int                SEL_W     = 3,
  parameter logic [DATA_W-1:0] MSTOP_RST = 16'h3FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pin_dis,
  output logic [SEL_W-1:0]  rate_sel,
  output logic [DATA_W-1:0] mstop
);
  import clkdiv_pkg::*;

  logic              dis_q,   dis_d;
  logic              spare_q, spare_d;
  logic [SEL_W-1:0]  sel_q,   sel_d;
  logic [DATA_W-1:0] mst_q,   mst_d;
  logic              ctl_we,  mst_we;
  logic [DATA_W-1:0] ctl_view;

  assign ctl_we = wr_en & ~wr_sel;
  assign mst_we = wr_en &  wr_sel;

  // control register next state
  always_comb begin
    dis_d   = dis_q;
    spare_d = spare_q;
    sel_d   = sel_q;
    if (ctl_we) begin
      dis_d   = wdata[CTL_DIS_BIT];
      spare_d = wdata[CTL_SPARE_BIT];
      sel_d   = wdata[SEL_W-1:0];
    end
  end

  // stop register next state: hardware standby dominates writes
  always_comb begin
    mst_d = mst_q;
    if (hw_stby)     mst_d = MSTOP_RST;
    else if (mst_we) mst_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q   <= 1'b0;
      spare_q <= 1'b0;
      sel_q   <= '0;
      mst_q   <= MSTOP_RST;
    end else begin
      dis_q   <= dis_d;
      spare_q <= spare_d;
      sel_q   <= sel_d;
      mst_q   <= mst_d;
    end
  end

  always_comb begin
    ctl_view                = '0;
    ctl_view[CTL_DIS_BIT]   = dis_q;
    ctl_view[CTL_SPARE_BIT] = spare_q;
    ctl_view[SEL_W-1:0]     = sel_q;
  end

  assign rdata    = wr_sel ? mst_q : ctl_view;
  assign pin_dis  = dis_q;
  assign rate_sel = sel_q;
  assign mstop    = mst_q;
endmodule

// File: rtl/clkdiv_prescale.sv
module clkdiv_prescale #(
  parameter int PRE_W = 5,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_req,
  input  logic             run_ok,
  output logic             ce,
  output logic [PRE_W-1:0] cnt_o,
  output logic [SEL_W-1:0] act_o
);
  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic [SEL_W-1:0] act_q, act_d;
  logic             wrap;
  logic [PRE_W-1:0] mask;
  logic             fast;

  assign wrap = &cnt_q;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    act_d = wrap ? sel_req : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  // code k in 1..PRE_W picks a mask of k low ones; other codes run at full speed
  always_comb begin
    mask = '0;
    fast = 1'b1;
    for (int k = 1; k <= PRE_W; k++) begin
      if (act_q == SEL_W'(k)) begin
        mask = PRE_W'((1 << k) - 1);
        fast = 1'b0;
      end
    end
  end

  assign ce    = run_ok & (fast | ((cnt_q & mask) == mask));
  assign cnt_o = cnt_q;
  assign act_o = act_q;
endmodule

// File: rtl/clkdiv_pinout.sv
module clkdiv_pinout (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_run,
  input  logic pin_dis,
  input  logic hw_stby,
  output logic pin_o,
  output logic oe_o
);
  logic pin_q, pin_d;
  logic oe_q,  oe_d;

  always_comb begin
    pin_d = (pin_run & ~pin_dis) ? ~pin_q : 1'b1;
    oe_d  = ~hw_stby;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b1;
      oe_q  <= 1'b1;
    end else begin
      pin_q <= pin_d;
      oe_q  <= oe_d;
    end
  end

  assign pin_o = pin_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/clkdiv_ctl.sv
module clkdiv_ctl #(
  parameter int                 MSTOP_W   = 16,
  parameter int                 PRE_W     = 5,
  parameter int                 SEL_W     = 3,
  parameter logic [MSTOP_W-1:0] MSTOP_RST = 16'h3FFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         pwr_mode,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [MSTOP_W-1:0] reg_wdata,
  output logic [MSTOP_W-1:0] reg_rdata,
  output logic               bm_ce,
  output logic               clkout_o,
  output logic               clkout_oe,
  output logic [MSTOP_W-1:0] mstop_o
);
  import clkdiv_pkg::*;

  pmode_e           mode;
  logic             srst_n;
  logic             hw_stby;
  logic             active;
  logic             pin_dis;
  logic [SEL_W-1:0] rate_sel;
  logic [PRE_W-1:0] pre_cnt;
  logic [SEL_W-1:0] pre_act;

  assign mode    = pmode_e'(pwr_mode);
  assign hw_stby = (mode == PM_HWSTBY);
  assign active  = pm_is_active(mode);

  clkdiv_rstsync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  clkdiv_regs #(
    .DATA_W    (MSTOP_W),
    .SEL_W     (SEL_W),
    .MSTOP_RST (MSTOP_RST)
  ) u_regs (
    .clk      (clk),
    .rst_n    (srst_n),
    .hw_stby  (hw_stby),
    .wr_en    (reg_wr),
    .wr_sel   (reg_sel),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .pin_dis  (pin_dis),
    .rate_sel (rate_sel),
    .mstop    (mstop_o)
  );

  clkdiv_prescale #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk     (clk),
    .rst_n   (srst_n),
    .sel_req (rate_sel),
    .run_ok  (active),
    .ce      (bm_ce),
    .cnt_o   (pre_cnt),
    .act_o   (pre_act)
  );

  clkdiv_pinout u_pin (
    .clk     (clk),
    .rst_n   (srst_n),
    .pin_run (active),
    .pin_dis (pin_dis),
    .hw_stby (hw_stby),
    .pin_o   (clkout_o),
    .oe_o    (clkout_oe)
  );
endmodule

// File: rtl/clkdiv_ctl_chk.sv
module clkdiv_ctl_chk #(
  parameter int                 MSTOP_W   = 16,
  parameter int                 PRE_W     = 5,
  parameter int                 SEL_W     = 3,
  parameter logic [MSTOP_W-1:0] MSTOP_RST = 16'h3FFF
) (
  input logic               clk,
  input logic               srst_n,
  input logic [1:0]         pwr_mode,
  input logic               pin_dis,
  input logic [PRE_W-1:0]   pre_cnt,
  input logic [SEL_W-1:0]   pre_act,
  input logic               bm_ce,
  input logic               clkout_o,
  input logic               clkout_oe,
  input logic [MSTOP_W-1:0] mstop_o
);
  // R4: hardware standby reloads the stop pattern
  a_r4_hwstby_reload: assert property (@(posedge clk) disable iff (!srst_n)
    (pwr_mode == 2'b11) |=> (mstop_o == MSTOP_RST));

  // R10: pin released while in hardware standby
  a_r10_hwstby_float: assert property (@(posedge clk) disable iff (!srst_n)
    (pwr_mode == 2'b11) |=> !clkout_oe);

  // R7: no bus-master enable in either standby
  a_r7_standby_no_ce: assert property (@(posedge clk) disable iff (!srst_n)
    pwr_mode[1] |-> !bm_ce);

  // R9: software standby holds the pin high
  a_r9_swstby_high: assert property (@(posedge clk) disable iff (!srst_n)
    (pwr_mode == 2'b10) |=> clkout_o);

  // R8: disabled pin holds high in run and sleep
  a_r8_disabled_high: assert property (@(posedge clk) disable iff (!srst_n)
    (!pwr_mode[1] && pin_dis) |=> clkout_o);

  // R8: enabled pin toggles in run and sleep
  a_r8_pin_toggles: assert property (@(posedge clk) disable iff (!srst_n)
    (!pwr_mode[1] && !pin_dis) |=> (clkout_o != $past(clkout_o)));

  // R6: rate code in use only changes at the prescaler wrap
  a_r6_rate_held: assert property (@(posedge clk) disable iff (!srst_n)
    !(&pre_cnt) |=> $stable(pre_act));
endmodule

bind clkdiv_ctl clkdiv_ctl_chk #(
  .MSTOP_W   (MSTOP_W),
  .PRE_W     (PRE_W),
  .SEL_W     (SEL_W),
  .MSTOP_RST (MSTOP_RST)
) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .pwr_mode  (pwr_mode),
  .pin_dis   (pin_dis),
  .pre_cnt   (pre_cnt),
  .pre_act   (pre_act),
  .bm_ce     (bm_ce),
  .clkout_o  (clkout_o),
  .clkout_oe (clkout_oe),
  .mstop_o   (mstop_o)
);

// File: tb/clkdiv_ctl_bench.sv
`timescale 1ns/1ps
module clkdiv_ctl_bench;
  logic        clk;
  logic        rst_n;
  logic [1:0]  pwr_mode;
  logic        reg_wr;
  logic        reg_sel;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        bm_ce;
  logic        clkout_o;
  logic        clkout_oe;
  logic [15:0] mstop_o;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  clkdiv_ctl u_clkdiv_ctl (
    .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bm_ce(bm_ce), .clkout_o(clkout_o), .clkout_oe(clkout_oe), .mstop_o(mstop_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- reference model built from the requirements ----------------
  logic [1:0]  m_sync;
  logic        m_rstn;
  logic [7:0]  m_ctl;
  logic [15:0] m_mst;
  logic [4:0]  m_cnt;
  logic [2:0]  m_act;
  logic        m_pin, m_oe;
  logic        m_hw_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_sync <= 2'b00;
    else        m_sync <= {m_sync[0], 1'b1};
  end
  assign m_rstn = m_sync[1];

  always @(posedge clk or negedge m_rstn) begin
    if (!m_rstn) begin
      m_ctl <= 8'h00; m_mst <= 16'h3FFF; m_cnt <= 5'd0; m_act <= 3'd0;
      m_pin <= 1'b1;  m_oe <= 1'b1;      m_hw_prev <= 1'b0;
    end else begin
      if (reg_wr && !reg_sel) m_ctl <= reg_wdata[7:0] & 8'hC7;
      if (pwr_mode == 2'b11)  m_mst <= 16'h3FFF;
      else if (reg_wr && reg_sel) m_mst <= reg_wdata;
      m_cnt <= m_cnt + 5'd1;
      if (m_cnt == 5'd31) m_act <= m_ctl[2:0];
      m_pin <= (!pwr_mode[1] && !m_ctl[7]) ? ~m_pin : 1'b1;
      m_oe  <= (pwr_mode != 2'b11);
      m_hw_prev <= (pwr_mode == 2'b11);
    end
  end

  function automatic logic exp_ce(logic [1:0] md, logic [2:0] act, logic [4:0] cnt);
    logic [4:0] msk;
    if (md[1]) return 1'b0;
    if (act == 3'd0 || act > 3'd5) return 1'b1;
    msk = 5'((1 << act) - 1);
    return (cnt & msk) == msk;
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(reg_sel ? "R3" : "R2", "reg_rdata", reg_rdata, reg_sel ? m_mst : {8'h00, m_ctl});
    chk(m_hw_prev ? "R4" : "R3", "mstop_o", mstop_o, m_mst);
    chk(pwr_mode[1] ? "R7" : ((m_act == m_ctl[2:0]) ? "R5" : "R6"), "bm_ce",
        {15'd0, bm_ce}, {15'd0, exp_ce(pwr_mode, m_act, m_cnt)});
    chk(m_hw_prev ? "R10" : "R8", "clkout_oe", {15'd0, clkout_oe}, {15'd0, m_oe});
    chk(m_oe ? "R8" : "R9", "clkout_o", {15'd0, clkout_o}, {15'd0, m_pin});
  endtask

  // drive at the falling edge, check shortly after, then wait a cycle
  task automatic step(logic [1:0] md, logic wr, logic sel, logic [15:0] wd);
    pwr_mode = md; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    #1;
    compare_all();
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd24681));
    rst_n = 1'b0; pwr_mode = 2'b00; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = 16'h0;
    repeat (3) @(negedge clk);
    // R1: reset values
    reg_sel = 1'b0; #1;
    chk("R1", "ctl reset", reg_rdata, 16'h0000);
    chk("R1", "pin reset", {14'd0, clkout_o, clkout_oe}, 16'h0003);
    reg_sel = 1'b1; #1;
    chk("R1", "stop reset", reg_rdata, 16'h3FFF);
    chk("R1", "stop lines reset", mstop_o, 16'h3FFF);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(2'b00, 1'b0, 1'b1, 16'h0);

    // R2: reserved bits read zero
    step(2'b00, 1'b1, 1'b0, 16'hFFFF);
    reg_sel = 1'b0; #1; chk("R2", "ctl masked", reg_rdata, 16'h00C7);
    step(2'b00, 1'b1, 1'b0, 16'h0000);
    // R3: stop register pattern
    step(2'b00, 1'b1, 1'b1, 16'hA5C3);
    reg_sel = 1'b1; #1; chk("R3", "stop readback", mstop_o, 16'hA5C3);
    // R4: software standby keeps, hardware standby reloads and ignores writes
    repeat (5) step(2'b10, 1'b0, 1'b1, 16'h0);
    chk("R4", "sw standby keeps", mstop_o, 16'hA5C3);
    repeat (4) step(2'b11, 1'b1, 1'b1, 16'h0000);
    chk("R4", "hw standby reload", mstop_o, 16'h3FFF);
    chk("R10", "hw standby oe", {15'd0, clkout_oe}, 16'h0000);

    // R5/R6: each rate code with a mid-frame change
    for (int c = 0; c < 8; c++) begin
      step(2'b00, 1'b1, 1'b0, 16'(c));
      repeat (45) step(2'b00, 1'b0, 1'b0, 16'h0);
    end
    // R8: pin disabled then enabled
    step(2'b00, 1'b1, 1'b0, 16'h0080);
    repeat (6) step(2'b01, 1'b0, 1'b0, 16'h0);
    chk("R8", "disabled pin high", {15'd0, clkout_o}, 16'h0001);
    step(2'b00, 1'b1, 1'b0, 16'h0003);

    // random phase
    begin
      logic [1:0] md;
      md = 2'b00;
      for (int i = 0; i < 4000; i++) begin
        logic [31:0] r;
        r = $urandom;
        if (r[3:0] == 4'd0) begin
          case (r[6:4])
            3'd0, 3'd1, 3'd2: md = 2'b00;
            3'd3:             md = 2'b01;
            3'd4, 3'd5:       md = 2'b10;
            default:          md = 2'b11;
          endcase
        end
        step(md, r[9:8] == 2'b00, r[10], $urandom);
      end
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule